// File: doc/BRIEF.md
# SMBus Line Watcher with Timeouts and SDA Pacing

This block observes the clock and data wires of a two-wire SMBus segment and keeps a bus-busy flag. A START (data falling while clock is high) marks the bus busy; a STOP (data rising while clock is high) or an expired bus-free window marks it idle again. Both wires pass through two-flop synchronizers before any edge is examined.

Two timeouts run from the system clock. The bus-free window requires both wires to be high for more than 50 µs. The clock-low window requires the clock wire to be low for 25 ms without a break. Both are derived from a clock-frequency parameter. The block also paces a transmitter: after each clock falling edge it signals when SDA may change (hold elapsed) and when SDA is settled so that the clock may be released (setup elapsed). A slave-event interrupt pulses on every START and STOP unless the slave is muted.

Top module: `smb_line_watch`

## Requirements
- R1: While `mon_en` is 0, `bus_busy`, `slv_irq`, `free_evt`, `sda_chg_ok` and `sda_stable` stay 0 and `lowto_flag` is never set, whatever the wires do.
- R2: With `mon_en` at 1, SDA falling while SCL is high sets `bus_busy`. SDA rising while SCL is high clears it.
- R3: With `freeto_en` at 1, once SCL and SDA have both been high for FREE_US microseconds (CLK_HZ*FREE_US/10^6 cycles), `bus_busy` clears and `free_evt` pulses for exactly one cycle. With `freeto_en` at 0, `bus_busy` stays set.
- R4: With `lowto_en` at 1, `lowto_flag` sets after SCL has been low without a break for LOW_MS milliseconds (CLK_HZ*LOW_MS/1000 cycles). Any SCL-high interval restarts the count. With `lowto_en` at 0 the flag never sets.
- R5: `lowto_flag` stays set until `lowto_clr` is pulsed high.
- R6: With `long_hold` at 0, `sda_chg_ok` pulses 3 cycles after the synchronized SCL fall, and `sda_stable` pulses 4 cycles after that. At the pins this is 5 and 9 cycles after the clock edge that first samples SCL low.
- R7: With `long_hold` at 1, the hold is 12 cycles and the setup is 11 cycles. At the pins the pulses come 14 and 25 cycles after the clock edge that first samples SCL low.
- R8: `slv_irq` pulses for one cycle on each START and STOP while `slv_mute` is 0. While `slv_mute` is 1 it stays low, and `bus_busy` still tracks START and STOP.
- R9: A synchronous active-high `rst` clears `bus_busy`, `lowto_flag`, all pulses and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitoring enable |
| slv_mute | input | 1 | Suppresses the slave-event interrupt |
| long_hold | input | 1 | Selects the 12/11 hold/setup spacing |
| lowto_en | input | 1 | Enables the SCL-low timeout |
| freeto_en | input | 1 | Enables the bus-free timeout |
| lowto_clr | input | 1 | Clears the sticky SCL-low timeout flag |
| scl_i | input | 1 | Raw SCL wire |
| sda_i | input | 1 | Raw SDA wire |
| bus_busy | output | 1 | Transfer in progress |
| lowto_flag | output | 1 | Sticky SCL-low timeout |
| free_evt | output | 1 | One-cycle bus-free timeout event |
| slv_irq | output | 1 | One-cycle slave-event interrupt |
| sda_chg_ok | output | 1 | Hold elapsed; SDA may change |
| sda_stable | output | 1 | Setup elapsed; SCL may be released |

## Verification
The bench holds SCL low for just under the timeout, releases it briefly, and then holds it low again. A counter without a reload would raise the timeout flag early. The bench leaves the bus busy with both wires high, with the free timeout off and then on. A design that forgot the enable, or one that fired the event more than once, is caught at the ports. A scoreboard measures the strobe latencies in both spacing modes, so swapped hold and setup values or an off-by-one count show up as a wrong cycle number. The bench also checks that muting the slave silences the interrupt but not the busy flag, and that a disabled monitor ignores a full START, low and STOP sequence.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
  localparam int unsigned PH_W = 5;

  // cycles in n units of 1/per_s seconds, never below one
  function automatic int unsigned span_cycles(int unsigned hz, int unsigned n,
                                              int unsigned per_s);
    longint unsigned p;
    p = (longint'(hz) * longint'(n)) / longint'(per_s);
    if (p < 1) p = 1;
    return p[31:0];
  endfunction

  function automatic logic [PH_W-1:0] hold_cycles(logic long_hold);
    return long_hold ? PH_W'(12) : PH_W'(3);
  endfunction

  function automatic logic [PH_W-1:0] setup_cycles(logic long_hold);
    return long_hold ? PH_W'(11) : PH_W'(4);
  endfunction
endpackage

// File: rtl/smbw_sync2.sv
module smbw_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/smbw_span_timer.sv
module smbw_span_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign fire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/smbw_sda_pacer.sv
module smbw_sda_pacer
  import smbw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_s,
  input  logic scl_fall,
  input  logic long_hold,
  output logic chg_ok,
  output logic stable
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] hold_n;
  logic [PH_W-1:0] last_n;

  assign hold_n = hold_cycles(long_hold);
  assign last_n = hold_n + setup_cycles(long_hold);

  always_ff @(posedge clk) begin
    if (rst || !en || scl_s) ph <= '0;
    else if (scl_fall)       ph <= PH_W'(1);
    else if (ph != '0)       ph <= (ph == last_n) ? '0 : ph + 1'b1;
  end

  assign chg_ok = (ph == hold_n);
  assign stable = (ph == last_n);
endmodule

// File: rtl/smb_line_watch.sv
module smb_line_watch
  import smbw_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 20_000_000,
  parameter int unsigned FREE_US = 50,
  parameter int unsigned LOW_MS  = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_en,
  input  logic slv_mute,
  input  logic long_hold,
  input  logic lowto_en,
  input  logic freeto_en,
  input  logic lowto_clr,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_busy,
  output logic lowto_flag,
  output logic free_evt,
  output logic slv_irq,
  output logic sda_chg_ok,
  output logic sda_stable
);
  localparam int unsigned FREE_LIM = span_cycles(CLK_HZ, FREE_US, 1_000_000);
  localparam int unsigned LOW_LIM  = span_cycles(CLK_HZ, LOW_MS, 1_000);

  logic [1:0] sync_q;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_fall, start_seen, stop_seen;
  logic free_run, free_fire, low_run, low_fire;

  smbw_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // line events, only while monitoring
  assign scl_fall   = mon_en && scl_d && !scl_s;
  assign start_seen = mon_en && scl_d && scl_s && sda_d && !sda_s;
  assign stop_seen  = mon_en && scl_d && scl_s && !sda_d && sda_s;

  assign free_run = mon_en && freeto_en && scl_s && sda_s;
  assign low_run  = mon_en && lowto_en && !scl_s;

  smbw_span_timer #(.LIMIT(FREE_LIM)) u_free (
    .clk(clk), .rst(rst), .run(free_run), .fire(free_fire)
  );
  smbw_span_timer #(.LIMIT(LOW_LIM)) u_low (
    .clk(clk), .rst(rst), .run(low_run), .fire(low_fire)
  );

  always_ff @(posedge clk) begin
    if (rst || !mon_en)             bus_busy <= 1'b0;
    else if (stop_seen || free_fire) bus_busy <= 1'b0;
    else if (start_seen)            bus_busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            lowto_flag <= 1'b0;
    else if (low_fire)  lowto_flag <= 1'b1;
    else if (lowto_clr) lowto_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_evt <= 1'b0;
      slv_irq  <= 1'b0;
    end else begin
      free_evt <= free_fire;
      slv_irq  <= !slv_mute && (start_seen || stop_seen);
    end
  end

  smbw_sda_pacer u_pace (
    .clk(clk), .rst(rst), .en(mon_en), .scl_s(scl_s), .scl_fall(scl_fall),
    .long_hold(long_hold), .chg_ok(sda_chg_ok), .stable(sda_stable)
  );
endmodule

// File: rtl/smbw_checks.sv
module smbw_checks (
  input logic clk,
  input logic rst,
  input logic mon_en,
  input logic slv_mute,
  input logic lowto_clr,
  input logic scl_s,
  input logic start_seen,
  input logic bus_busy,
  input logic lowto_flag,
  input logic free_evt,
  input logic slv_irq,
  input logic sda_chg_ok,
  input logic sda_stable
);
  a_r1_off_means_idle: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> (!bus_busy && !slv_irq));
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> $past(start_seen));
  a_r3_free_single: assert property (@(posedge clk) disable iff (rst)
    free_evt |=> !free_evt);
  a_r4_flag_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(lowto_flag) |-> $past(!scl_s));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(lowto_flag) |-> $past(lowto_clr));
  a_r6_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(sda_chg_ok && sda_stable));
  a_r8_mute_silences: assert property (@(posedge clk) disable iff (rst)
    slv_irq |-> $past(!slv_mute && mon_en));
endmodule

bind smb_line_watch smbw_checks u_chk (
  .clk(clk), .rst(rst), .mon_en(mon_en), .slv_mute(slv_mute),
  .lowto_clr(lowto_clr), .scl_s(scl_s), .start_seen(start_seen),
  .bus_busy(bus_busy), .lowto_flag(lowto_flag), .free_evt(free_evt),
  .slv_irq(slv_irq), .sda_chg_ok(sda_chg_ok), .sda_stable(sda_stable)
);

// File: tb/sim_smb_line_watch.sv
`timescale 1ns/1ps
module sim_smb_line_watch;
  localparam int unsigned HZ = 200_000;   // 10-cycle free window, 5000-cycle low window
  localparam int FREE_N = 10;
  localparam int LOW_N  = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon_en = 1'b0, slv_mute = 1'b0, long_hold = 1'b0;
  logic lowto_en = 1'b0, freeto_en = 1'b0, lowto_clr = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic bus_busy, lowto_flag, free_evt, slv_irq, sda_chg_ok, sda_stable;

  always #4 clk = ~clk;

  smb_line_watch #(.CLK_HZ(HZ), .FREE_US(50), .LOW_MS(25)) u0 (
    .clk(clk), .rst(rst), .mon_en(mon_en), .slv_mute(slv_mute),
    .long_hold(long_hold), .lowto_en(lowto_en), .freeto_en(freeto_en),
    .lowto_clr(lowto_clr), .scl_i(scl_i), .sda_i(sda_i),
    .bus_busy(bus_busy), .lowto_flag(lowto_flag), .free_evt(free_evt),
    .slv_irq(slv_irq), .sda_chg_ok(sda_chg_ok), .sda_stable(sda_stable)
  );

  int checks = 0, failures = 0;
  int cyc = 0, drive_cyc = 0;
  int irq_n = 0, free_n = 0, strobe_n = 0;
  bit done = 1'b0;

  typedef struct { bit is_setup; int lat; } exp_t;
  exp_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts pulses and pops scoreboard items on strobes
  always @(negedge clk) begin
    if (!rst) begin
      if (slv_irq) irq_n++;
      if (free_evt) free_n++;
      if (sda_chg_ok || sda_stable) strobe_n++;
      if ((sda_chg_ok || sda_stable) && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.is_setup == sda_stable, sda_stable ? "R6/R7 kind(stable)" : "R6/R7 kind(chg)",
              int'(sda_stable), int'(e.is_setup));
        check(cyc - drive_cyc == e.lat, e.is_setup ? "R6/R7 setup latency" : "R6/R7 hold latency",
              cyc - drive_cyc, e.lat);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pace_run(bit ext, int h, int s, int low_len);
    long_hold = ext;
    sb.push_back('{1'b0, h + 2});
    sb.push_back('{1'b1, h + s + 2});
    tick(1);
    scl_i = 1'b0;
    drive_cyc = cyc;
    tick(low_len);
    scl_i = 1'b1;
    tick(6);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R9 reset state
    check(bus_busy == 0, "R9 busy after reset", bus_busy, 0);
    check(lowto_flag == 0 && free_evt == 0 && slv_irq == 0, "R9 flags after reset",
          lowto_flag, 0);

    // R1 disabled monitor ignores wires
    lowto_en = 1'b1; freeto_en = 1'b1;
    sda_i = 1'b0; tick(6);
    check(bus_busy == 0, "R1 busy while off", bus_busy, 0);
    scl_i = 1'b0; tick(40);
    scl_i = 1'b1; tick(4); sda_i = 1'b1; tick(30);
    check(irq_n == 0, "R1 irq while off", irq_n, 0);
    check(strobe_n == 0, "R1 strobes while off", strobe_n, 0);
    check(free_n == 0, "R1 free event while off", free_n, 0);
    freeto_en = 1'b0;

    mon_en = 1'b1; tick(6);
    irq_n = 0;
    // R2 START / STOP, R8 interrupt
    sda_i = 1'b0; tick(6);
    check(bus_busy == 1, "R2 busy after START", bus_busy, 1);
    check(irq_n == 1, "R8 irq on START", irq_n, 1);
    sda_i = 1'b1; tick(6);
    check(bus_busy == 0, "R2 idle after STOP", bus_busy, 0);
    check(irq_n == 2, "R8 irq on STOP", irq_n, 2);

    // R8 muted slave
    slv_mute = 1'b1;
    sda_i = 1'b0; tick(6);
    check(bus_busy == 1, "R8 busy tracked while muted", bus_busy, 1);
    sda_i = 1'b1; tick(6);
    check(bus_busy == 0, "R8 STOP tracked while muted", bus_busy, 0);
    check(irq_n == 2, "R8 no irq while muted", irq_n, 2);
    slv_mute = 1'b0;

    // R3 busy bus parked with both lines high
    sda_i = 1'b0; tick(4); scl_i = 1'b0; tick(4);
    sda_i = 1'b1; tick(4); scl_i = 1'b1; tick(40);
    check(bus_busy == 1, "R3 busy kept, free timeout off", bus_busy, 1);
    check(free_n == 0, "R3 no free event when off", free_n, 0);
    freeto_en = 1'b1; tick(FREE_N + 8);
    check(bus_busy == 0, "R3 busy cleared by free timeout", bus_busy, 0);
    tick(20);
    check(free_n == 1, "R3 single free event", free_n, 1);
    freeto_en = 1'b0;

    // R4 low timeout with reload
    scl_i = 1'b0; tick(LOW_N - 20);
    scl_i = 1'b1; tick(3);
    scl_i = 1'b0; tick(LOW_N - 20);
    check(lowto_flag == 0, "R4 reload on SCL high", lowto_flag, 0);
    tick(40);
    check(lowto_flag == 1, "R4 flag after long low", lowto_flag, 1);
    scl_i = 1'b1; tick(10);
    check(lowto_flag == 1, "R5 flag sticky", lowto_flag, 1);
    lowto_clr = 1'b1; tick(1); lowto_clr = 1'b0; tick(2);
    check(lowto_flag == 0, "R5 flag cleared", lowto_flag, 0);
    lowto_en = 1'b0;
    scl_i = 1'b0; tick(LOW_N + 50);
    check(lowto_flag == 0, "R4 no flag when disabled", lowto_flag, 0);
    scl_i = 1'b1; tick(6);

    // R6 / R7 strobe spacing via scoreboard
    pace_run(1'b0, 3, 4, 30);
    pace_run(1'b1, 12, 11, 40);
    check(sb.size() == 0, "R6/R7 all strobes seen", sb.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule